// File: doc/BRIEF.md
# Timed Digital I/O Channel Controller

This block manages five digital I/O channels against a shared system time base made of a seconds count and a cycle count within the second. A channel set up as an input timestamps every rising edge on its pin. The stamp goes into a small queue for that channel, and an interrupt line tells software that stamps are waiting. A channel set up as an output drives a pulse of programmable width. The pulse fires either straight away or in the cycle when the time base reaches a programmed target. Both directions are resolved to one system clock tick.

Software uses a flat register port. The upper address nibble selects a channel, with value 0xF for the global registers, and the lower nibble selects a register. Each output channel holds at most one scheduled pulse. Arming it again replaces the request that was waiting. The time base comes from outside the block, and the block does not generate it.

Output channel states are `OUT_IDLE`, `OUT_WAIT` and `OUT_PULSE`. The transitions are:
- arm-immediate: any state to `OUT_PULSE`.
- arm-scheduled: any state to `OUT_WAIT`.
- target reached, or target was already past when armed: `OUT_WAIT` to `OUT_PULSE`.
- width exhausted: `OUT_PULSE` to `OUT_IDLE`.
- channel switched to input: any state to `OUT_IDLE`.

The input edge detector has two states, `IN_LOW` and `IN_HIGH`. It follows the synchronised pin, and the `IN_LOW` to `IN_HIGH` step is the capture event.

Per-channel registers (offset in the low nibble):

| Offset | Access | Contents |
|---|---|---|
| 0 | read/write | bit0 = 1 for output |
| 1 | read/write | target seconds |
| 2 | read/write | target cycles |
| 3 | read/write | pulse width |
| 4 | write | arm: bit0 = scheduled, bit1 = immediate |
| 5 | read | status: bit0 pending, bit1 late, bit2 overflow, bit3 queue non-empty, bits 6:4 queue count |
| 5 | write | writing 1 to bit1 clears late; writing 1 to bit2 clears overflow |
| 6 | read | head stamp seconds (no pop) |
| 7 | read | head stamp cycles (pops when `rd_en` is high) |

Global registers:

| Address | Access | Contents |
|---|---|---|
| 0xF0 | read | per-channel queue non-empty bits |
| 0xF1 | read/write | interrupt enable mask |

Top module: `tdio_ctrl`

## Requirements
- R1: After reset, `dio_out`, `dio_oe` and `irq` are 0 and every channel status reads 0.
- R2: Writing bit0 of offset 0 makes the channel an output and raises its `dio_oe` bit. An arm write to a channel in input mode is ignored: pending stays 0 and the pin stays low.
- R3: In input mode, a rising edge on `dio_in` pushes the time `{time_sec, time_cyc}` sampled on the third rising clock edge after the pin goes high.
- R4: Stamps leave the queue oldest first, up to 4 entries. Reading offset 6 does not pop. Reading offset 7 with `rd_en` high pops.
- R5: A stamp that arrives while 4 are queued is dropped. The sticky overflow bit (status bit2) is set and stays set until 1 is written to status bit2.
- R6: `irq` is the OR over channels of (queue non-empty AND enable bit in 0xF1). Register 0xF0 shows the non-empty bits.
- R7: An immediate arm (bit1 of offset 4) drives the pin high from the clock edge that takes the write, for exactly the width in cycles.
- R8: A scheduled arm (bit0 of offset 4) drives the pin high from the clock edge at which the sampled time equals the target, for the width in cycles.
- R9: If the target is less than or equal to the time sampled with the arm write, the pulse starts one edge after the arm and status bit1 (late) is set. Writing 1 to status bit1 clears it.
- R10: A new arm replaces any pending request and ends any pulse in progress. Only the newest request produces a pulse.
- R11: Status bit0 (pending) is 1 from the edge that takes a scheduled arm until the pulse starts. It is never 1 while the pin is high.
- R12: A width of 0 gives a 1-cycle pulse.
- R13: A channel in output mode records no stamps from its `dio_in` pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address: channel nibble, register nibble |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; pops the queue at offset 7 |
| rdata | output | 32 | Read data for `addr` (combinational) |
| time_sec | input | 32 | Time base, seconds |
| time_cyc | input | 27 | Time base, cycles within the second |
| dio_in | input | 5 | Channel input pins |
| dio_out | output | 5 | Channel output pins |
| dio_oe | output | 5 | Output enable per channel |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps pulse widths from 0 to 6 and checks the exact first cycle and length of every pulse. A design that miscounted the width, or ignored the zero case, would give a pulse one cycle too long or too short, or no pulse at all. Scheduled targets are placed several cycles ahead, on a seconds boundary, exactly on the arm cycle and well in the past. A design that compared with strict less-than, or misjudged lateness, would stall in the wait state or raise the late flag wrongly. The bench re-arms a channel to both earlier and later targets, and cancels a scheduled pulse with an immediate one, so a design that kept the old request would give two pulses or fire at the wrong time. On the input side it overfills a queue by one and checks that the oldest four stamps survive in order with the overflow flag set. It also checks that the interrupt follows the enable mask and that an output-mode channel takes no stamps.

// File: rtl/tdio_pkg.sv
package tdio_pkg;

    localparam int OFF_W = 4;

    // per-channel register offsets (low address nibble)
    localparam logic [OFF_W-1:0] REG_CTRL  = 4'h0;
    localparam logic [OFF_W-1:0] REG_TSEC  = 4'h1;
    localparam logic [OFF_W-1:0] REG_TCYC  = 4'h2;
    localparam logic [OFF_W-1:0] REG_WIDTH = 4'h3;
    localparam logic [OFF_W-1:0] REG_ARM   = 4'h4;
    localparam logic [OFF_W-1:0] REG_STAT  = 4'h5;
    localparam logic [OFF_W-1:0] REG_QSEC  = 4'h6;
    localparam logic [OFF_W-1:0] REG_QCYC  = 4'h7;

    // global register offsets (channel nibble all ones)
    localparam logic [OFF_W-1:0] REG_IRQ_STAT = 4'h0;
    localparam logic [OFF_W-1:0] REG_IRQ_EN   = 4'h1;

    // arm word bits
    localparam int ARM_SCHED = 0;
    localparam int ARM_NOW   = 1;

    // status word bits
    localparam int ST_PEND   = 0;
    localparam int ST_LATE   = 1;
    localparam int ST_OVF    = 2;
    localparam int ST_NEMPTY = 3;
    localparam int ST_CNT    = 4;

    typedef enum logic [1:0] {
        OUT_IDLE  = 2'd0,
        OUT_WAIT  = 2'd1,
        OUT_PULSE = 2'd2
    } out_state_t;

    typedef enum logic {
        IN_LOW  = 1'b0,
        IN_HIGH = 1'b1
    } in_state_t;

endpackage

// File: rtl/tdio_sync.sv
module tdio_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sr;

    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-2:0], d};
    end

    assign q = sr[STAGES-1];
endmodule

// File: rtl/tdio_stamp_fifo.sv
module tdio_stamp_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 59,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             drop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          full, empty, do_push, do_pop;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && !do_push;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + PW'(1);
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + PW'(1);
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assign dout = mem[rp];
endmodule

// File: rtl/tdio_in_chan.sv
module tdio_in_chan
    import tdio_pkg::*;
#(
    parameter int TW    = 59,
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin,
    input  logic             enable,
    input  logic [TW-1:0]    now,
    input  logic             pop,
    input  logic             clr_ovf,
    output logic [TW-1:0]    head,
    output logic [CNT_W-1:0] count,
    output logic             nonempty,
    output logic             ovf
);
    logic      pin_s;
    in_state_t state, state_d;
    logic      rise, capture, drop;

    tdio_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin),
        .q    (pin_s)
    );

    // next state
    always_comb begin
        unique case (state)
            IN_LOW:  state_d = pin_s ? IN_HIGH : IN_LOW;
            IN_HIGH: state_d = pin_s ? IN_HIGH : IN_LOW;
            default: state_d = IN_LOW;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= IN_LOW;
        else        state <= state_d;
    end

    // outputs
    always_comb begin
        rise    = (state == IN_LOW) && pin_s;
        capture = rise && enable;
    end

    tdio_stamp_fifo #(.DEPTH(DEPTH), .W(TW), .CNT_W(CNT_W)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (capture),
        .pop  (pop),
        .din  (now),
        .dout (head),
        .count(count),
        .drop (drop)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ovf <= 1'b0;
        else if (drop)    ovf <= 1'b1;
        else if (clr_ovf) ovf <= 1'b0;
    end

    assign nonempty = (count != '0);
endmodule

// File: rtl/tdio_out_chan.sv
module tdio_out_chan
    import tdio_pkg::*;
#(
    parameter int TW    = 59,
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [TW-1:0]    now,
    input  logic [TW-1:0]    target,
    input  logic [WID_W-1:0] width,
    input  logic             arm_sched,
    input  logic             arm_now,
    input  logic             clr_late,
    output logic             pulse,
    output logic             pending,
    output logic             late
);
    out_state_t       state, state_d;
    logic [TW-1:0]    tgt_q;
    logic             asap_q;
    logic [WID_W-1:0] wcnt_q, wid_eff;
    logic             past, take_sched, load_w;

    assign wid_eff    = (width == '0) ? WID_W'(1) : width;
    assign past       = (target <= now);
    assign take_sched = enable && arm_sched && !arm_now;
    assign load_w     = (state_d == OUT_PULSE) && ((state != OUT_PULSE) || (enable && arm_now));

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            OUT_IDLE:  state_d = OUT_IDLE;
            OUT_WAIT:  if (asap_q || (now == tgt_q)) state_d = OUT_PULSE;
            OUT_PULSE: if (wcnt_q <= WID_W'(1)) state_d = OUT_IDLE;
            default:   state_d = OUT_IDLE;
        endcase
        if (!enable)        state_d = OUT_IDLE;
        else if (arm_now)   state_d = OUT_PULSE;
        else if (arm_sched) state_d = OUT_WAIT;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= OUT_IDLE;
        else        state <= state_d;
    end

    // request and width datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q  <= '0;
            asap_q <= 1'b0;
            wcnt_q <= '0;
            late   <= 1'b0;
        end else begin
            if (take_sched) begin
                tgt_q  <= target;
                asap_q <= past;
            end
            if (load_w)                                  wcnt_q <= wid_eff;
            else if (state == OUT_PULSE && wcnt_q != '0) wcnt_q <= wcnt_q - WID_W'(1);
            if (take_sched && past) late <= 1'b1;
            else if (clr_late)      late <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        pulse   = (state == OUT_PULSE);
        pending = (state == OUT_WAIT);
    end
endmodule

// File: rtl/tdio_ctrl.sv
module tdio_ctrl
    import tdio_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int SEC_W  = 32,
    parameter int CYC_W  = 27,
    parameter int DEPTH  = 4,
    parameter int WID_W  = 16,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic [SEC_W-1:0]  time_sec,
    input  logic [CYC_W-1:0]  time_cyc,
    input  logic [NUM_CH-1:0] dio_in,
    output logic [NUM_CH-1:0] dio_out,
    output logic [NUM_CH-1:0] dio_oe,
    output logic              irq
);
    localparam int TW    = SEC_W + CYC_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int SEL_W = ADDR_W - OFF_W;
    localparam logic [SEL_W-1:0] GLOBAL_SEL = '1;

    logic [SEL_W-1:0]        sel;
    logic [OFF_W-1:0]        off;
    logic [TW-1:0]           now;
    logic [NUM_CH-1:0]       mode, pend_vec, pulse_vec, nonempty_vec;
    logic [NUM_CH-1:0]       ien;
    logic [NUM_CH*CNT_W-1:0] count_flat;
    logic [DATA_W-1:0]       rd_word [NUM_CH];

    assign sel = addr[ADDR_W-1:OFF_W];
    assign off = addr[OFF_W-1:0];
    assign now = {time_sec, time_cyc};

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);

        logic             hit, mode_q, late, ovf, pop, clr_late, clr_ovf;
        logic             arm_sched, arm_now;
        logic [SEC_W-1:0] tgt_sec;
        logic [CYC_W-1:0] tgt_cyc;
        logic [WID_W-1:0] wid;
        logic [TW-1:0]    head;
        logic [CNT_W-1:0] cnt;
        logic [DATA_W-1:0] word;

        assign hit       = (sel == MY_SEL);
        assign arm_sched = wr_en && hit && (off == REG_ARM) && wdata[ARM_SCHED];
        assign arm_now   = wr_en && hit && (off == REG_ARM) && wdata[ARM_NOW];
        assign clr_late  = wr_en && hit && (off == REG_STAT) && wdata[ST_LATE];
        assign clr_ovf   = wr_en && hit && (off == REG_STAT) && wdata[ST_OVF];
        assign pop       = rd_en && hit && (off == REG_QCYC);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mode_q  <= 1'b0;
                tgt_sec <= '0;
                tgt_cyc <= '0;
                wid     <= '0;
            end else if (wr_en && hit) begin
                case (off)
                    REG_CTRL:  mode_q  <= wdata[0];
                    REG_TSEC:  tgt_sec <= wdata[SEC_W-1:0];
                    REG_TCYC:  tgt_cyc <= wdata[CYC_W-1:0];
                    REG_WIDTH: wid     <= wdata[WID_W-1:0];
                    default:   ;
                endcase
            end
        end

        tdio_out_chan #(.TW(TW), .WID_W(WID_W)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .enable   (mode_q),
            .now      (now),
            .target   ({tgt_sec, tgt_cyc}),
            .width    (wid),
            .arm_sched(arm_sched),
            .arm_now  (arm_now),
            .clr_late (clr_late),
            .pulse    (pulse_vec[i]),
            .pending  (pend_vec[i]),
            .late     (late)
        );

        tdio_in_chan #(.TW(TW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_in (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin     (dio_in[i]),
            .enable  (!mode_q),
            .now     (now),
            .pop     (pop),
            .clr_ovf (clr_ovf),
            .head    (head),
            .count   (cnt),
            .nonempty(nonempty_vec[i]),
            .ovf     (ovf)
        );

        always_comb begin
            word = '0;
            case (off)
                REG_CTRL:  word[0] = mode_q;
                REG_TSEC:  word = DATA_W'(tgt_sec);
                REG_TCYC:  word = DATA_W'(tgt_cyc);
                REG_WIDTH: word = DATA_W'(wid);
                REG_STAT: begin
                    word[ST_PEND]            = pend_vec[i];
                    word[ST_LATE]            = late;
                    word[ST_OVF]             = ovf;
                    word[ST_NEMPTY]          = nonempty_vec[i];
                    word[ST_CNT +: CNT_W]    = cnt;
                end
                REG_QSEC:  word = DATA_W'(head[TW-1:CYC_W]);
                REG_QCYC:  word = DATA_W'(head[CYC_W-1:0]);
                default:   word = '0;
            endcase
        end

        assign rd_word[i]                       = word;
        assign mode[i]                          = mode_q;
        assign count_flat[i*CNT_W +: CNT_W]     = cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ien <= '0;
        else if (wr_en && sel == GLOBAL_SEL && off == REG_IRQ_EN) ien <= wdata[NUM_CH-1:0];
    end

    always_comb begin
        rdata = '0;
        if (sel == GLOBAL_SEL) begin
            if (off == REG_IRQ_STAT)    rdata = DATA_W'(nonempty_vec);
            else if (off == REG_IRQ_EN) rdata = DATA_W'(ien);
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (sel == SEL_W'(i)) rdata = rd_word[i];
            end
        end
    end

    assign dio_out = pulse_vec;
    assign dio_oe  = mode;
    assign irq     = |(nonempty_vec & ien);
endmodule

// File: rtl/tdio_ctrl_chk.sv
module tdio_ctrl_chk
    import tdio_pkg::*;
#(
    parameter int NUM_CH = 5,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [DATA_W-1:0]       wdata,
    input logic [NUM_CH-1:0]       dio_out,
    input logic                    irq,
    input logic [NUM_CH-1:0]       mode,
    input logic [NUM_CH-1:0]       pend,
    input logic [NUM_CH-1:0]       ien,
    input logic [NUM_CH*CNT_W-1:0] count_flat
);
    localparam int SEL_W = ADDR_W - OFF_W;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) (ien == '0) |-> !irq); // R6

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ast
        AST_PEND_NOT_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !(pend[i] && dio_out[i])); // R11
        AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count_flat[i*CNT_W +: CNT_W] <= CNT_W'(DEPTH)); // R5
        AST_IMM_FIRE: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == {SEL_W'(i), REG_ARM} && wdata[ARM_NOW] && mode[i]) |=> dio_out[i]); // R7
    end
endmodule

bind tdio_ctrl tdio_ctrl_chk #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .dio_out   (dio_out),
    .irq       (irq),
    .mode      (mode),
    .pend      (pend_vec),
    .ien       (ien),
    .count_flat(count_flat)
);

// File: tb/sim_tdio_ctrl.sv
module sim_tdio_ctrl;
    localparam int NCH  = 5;
    localparam int WRAP = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0, rdata;
    logic [31:0] time_sec;
    logic [26:0] time_cyc;
    logic [NCH-1:0] dio_in = '0, dio_out, dio_oe;
    logic        irq;
    int          tcount = 0;
    int          checks = 0, errors = 0;
    bit          done = 0;

    always #10 clk = ~clk;
    always @(posedge clk) tcount <= tcount + 1;
    assign time_sec = 32'(tcount / WRAP);
    assign time_cyc = 27'(tcount % WRAP);

    tdio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .time_sec(time_sec), .time_cyc(time_cyc),
        .dio_in(dio_in), .dio_out(dio_out), .dio_oe(dio_oe), .irq(irq)
    );

    function automatic logic [7:0] ca(input int ch, input int off);
        return {ch[3:0], off[3:0]};
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1; #1; d = rdata;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic measure(input int ch, input int len, output int rise, output int n);
        bit seen = 0;
        rise = -1; n = 0;
        for (int k = 0; k < len; k++) begin
            if (dio_out[ch]) begin
                if (!seen) rise = tcount;
                seen = 1; n++;
            end
            @(negedge clk);
        end
    endtask

    task automatic sched(input int ch, input int t);
        wr(ca(ch, 1), 32'(t / WRAP));
        wr(ca(ch, 2), 32'(t % WRAP));
        wr(ca(ch, 4), 32'h1);
    endtask

    task automatic in_pulse(input int ch, output int stamp);
        dio_in[ch] = 1'b1; stamp = tcount + 2;
        repeat (3) @(negedge clk);
        dio_in[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        int rise, n, t, ta, tb, tret;
        int st [5];

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 dio_out", dio_out, 0);
        chk("R1 dio_oe", dio_oe, 0);
        chk("R1 irq", irq, 0);
        for (int c = 0; c < NCH; c++) begin
            rd(ca(c, 5), d);
            chk("R1 status", d, 0);
        end

        // R2 mode select and ignored arm in input mode
        for (int c = 2; c < NCH; c++) wr(ca(c, 0), 1);
        chk("R2 oe", dio_oe, 5'b11100);
        wr(ca(0, 3), 4);
        wr(ca(0, 4), 3);
        measure(0, 8, rise, n);
        chk("R2 pin stays low", n, 0);
        rd(ca(0, 5), d);
        chk("R2 pending stays 0", d[0], 0);

        // R7 / R12 immediate pulses, width sweep
        for (int w = 0; w <= 6; w++) begin
            wr(ca(2, 3), w);
            wr(ca(2, 4), 2);
            tret = tcount;
            measure(2, 12, rise, n);
            chk("R7 immediate start", rise, tret);
            chk(w == 0 ? "R12 zero width" : "R7 width", n, (w == 0) ? 1 : w);
        end

        // R8 / R11 scheduled pulses
        for (int k = 0; k < 4; k++) begin
            wr(ca(3, 3), k + 1);
            if (k < 3) t = tcount + 12 + 7 * k;
            else begin
                t = (tcount / WRAP + 1) * WRAP;
                if (t < tcount + 12) t += WRAP;
            end
            sched(3, t);
            rd(ca(3, 5), d);
            chk("R11 pending after arm", d[0], 1);
            chk("R9 not late", d[1], 0);
            measure(3, t - tcount + k + 6, rise, n);
            chk("R8 scheduled start", rise, t + 1);
            chk("R8 scheduled width", n, k + 1);
            rd(ca(3, 5), d);
            chk("R11 pending cleared", d[0], 0);
        end

        // R9 late arming: equal, past, and just-in-time
        wr(ca(4, 3), 2);
        for (int k = 0; k < 3; k++) begin
            if (k == 0)      t = tcount + 2;
            else if (k == 1) t = tcount - 50;
            else             t = tcount + 3;
            sched(4, t);
            tret = tcount;
            measure(4, 8, rise, n);
            chk("R9 start one edge after arm", rise, tret + 1);
            chk("R9 width", n, 2);
            rd(ca(4, 5), d);
            chk("R9 late flag", d[1], (k < 2) ? 1 : 0);
            wr(ca(4, 5), 2);
            rd(ca(4, 5), d);
            chk("R9 late cleared", d[1], 0);
        end

        // R10 overwrite: later->earlier, earlier->later, sched->immediate
        wr(ca(3, 3), 2);
        ta = tcount + 60; tb = tcount + 30;
        sched(3, ta); sched(3, tb);
        measure(3, ta - tcount + 10, rise, n);
        chk("R10 earlier replaces", rise, tb + 1);
        chk("R10 single pulse", n, 2);
        ta = tcount + 30; tb = tcount + 60;
        sched(3, ta); sched(3, tb);
        measure(3, tb - tcount + 10, rise, n);
        chk("R10 later replaces", rise, tb + 1);
        chk("R10 single pulse", n, 2);
        ta = tcount + 30;
        sched(3, ta);
        wr(ca(3, 4), 2);
        tret = tcount;
        measure(3, ta - tcount + 10, rise, n);
        chk("R10 immediate cancels", rise, tret);
        chk("R10 single pulse", n, 2);

        // R13 output-mode channel takes no stamps
        in_pulse(2, t);
        rd(ca(2, 5), d);
        chk("R13 no stamp in output mode", d[6:3], 0);

        // R3 stamps on every channel
        for (int c = 2; c < NCH; c++) wr(ca(c, 0), 0);
        for (int c = 0; c < NCH; c++) begin
            in_pulse(c, t);
            rd(ca(c, 5), d);
            chk("R3 one stamp", d[6:4], 1);
            chk("R6 irq masked", irq, 0);
            rd(ca(c, 6), d);
            chk("R3 stamp seconds", d, t / WRAP);
            rd(ca(c, 7), d);
            chk("R3 stamp cycles", d, t % WRAP);
            rd(ca(c, 5), d);
            chk("R4 popped", d[6:3], 0);
        end

        // R4 / R5 / R6 queue order, overflow, interrupt
        wr(8'hF1, 32'h02);
        for (int k = 0; k < 5; k++) begin
            int s;
            in_pulse(1, s);
            if (k < 4) st[k] = s;
            if (k == 0) chk("R6 irq on stamp", irq, 1);
        end
        rd(8'hF0, d);
        chk("R6 irq status", d, 32'h02);
        wr(8'hF1, 32'h01);
        chk("R6 irq masked by enable", irq, 0);
        wr(8'hF1, 32'h02);
        chk("R6 irq enabled", irq, 1);
        rd(ca(1, 5), d);
        chk("R5 count full", d[6:4], 4);
        chk("R5 overflow set", d[2], 1);
        rd(ca(1, 6), d);
        rd(ca(1, 6), d2);
        chk("R4 peek no pop", d2, d);
        for (int k = 0; k < 4; k++) begin
            rd(ca(1, 6), d);
            chk("R4 order seconds", d, st[k] / WRAP);
            rd(ca(1, 7), d);
            chk("R4 order cycles", d, st[k] % WRAP);
        end
        chk("R6 irq after drain", irq, 0);
        rd(ca(1, 5), d);
        chk("R5 overflow sticky", d[2], 1);
        wr(ca(1, 5), 4);
        rd(ca(1, 5), d);
        chk("R5 overflow cleared", d[2], 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule